// File: doc/BRIEF.md
# Debug Run-Control Request Unit

This unit sits between a debugger's register bus and a processor core. The debugger sends 32-bit writes to a control word. Each write can ask the core to halt or to restart. It can also ask the core to drop its outstanding memory traffic, and it can clear sticky status flags. A halt, restart or cancel request is not a level that the debugger keeps driving. It is a write-one pulse that the unit latches and keeps asserted toward the core until the core acknowledges it by changing debug state.

Whether a write is accepted depends on the core's current debug state and on a debug-enable input. A halt is only taken while the core is running. A restart is only taken while it is halted. A cancel is only taken while debug is enabled.

A second word holds status that the debugger polls:
- the live halted indication;
- a restarted flag;
- three sticky exception flags;
- a sticky pipeline-advance flag.

The core sets these sticky flags with single-cycle pulses. The debugger clears them with write-one bits in the control word.

Top module: `dbg_runctl`

## Requirements
- R1: A write to the control word (address 0) with bit 0 set, while `core_in_debug` is low, drives `core_halt_req` high from the next cycle. It stays high until the cycle after `core_in_debug` is seen high. The same write while `core_in_debug` is high has no effect.
- R2: A control write with bit 1 set, while `core_in_debug` is high, drives `core_restart_req` high from the next cycle. It stays high until the cycle after `core_in_debug` is seen low. The same write while `core_in_debug` is low has no effect.
- R3: When bits 0 and 1 are written together, only the request legal in the current debug state is raised.
- R4: A control write with bit 4 set, while `dbg_enable` is high and the core is not in debug state, drives `core_cancel_req` high from the next cycle. It stays high until the cycle after `core_in_debug` is seen high. The write has no effect while `dbg_enable` is low.
- R5: A pulse on `core_exc_evt[i]` sets status bit 6+i from the next cycle. A control write with bit 2 set clears status bits 8:6. If a pulse and the clear fall in the same cycle, the pulsed flag stays set.
- R6: A pulse on `core_padv_evt` sets status bit 25. A control write with bit 3 set clears it, and a pulse in the same cycle wins. Bit 2 does not touch bit 25, and bit 3 does not touch bits 8:6.
- R7: Status bit 0 follows `core_in_debug` combinationally. Status bit 1 (restarted) clears on the cycle after a restart request is accepted. It sets on the cycle after `core_in_debug` falls.
- R8: Reading the control word (address 0) returns zero. Reading the status word (address 1) returns zero in every bit other than 0, 1, 8:6 and 25. Any other address also reads as zero.
- R9: After reset, all three requests and the restarted and sticky flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| dbg_enable | input | 1 | Debug enable; gates the cancel request |
| core_in_debug | input | 1 | Core is in debug state |
| core_exc_evt | input | 3 | Sticky exception set pulses |
| core_padv_evt | input | 1 | Sticky pipeline-advance set pulse |
| core_halt_req | output | 1 | Held halt request to the core |
| core_restart_req | output | 1 | Held restart request to the core |
| core_cancel_req | output | 1 | Held request to abandon memory traffic |

## Verification
The halt and restart bits are each written in both debug states. This separates state-gated acceptance from unconditional latching, and the combined write 0x3 in each state shows that only the legal request is raised. Requests are held for several idle cycles before the acknowledge arrives, which separates a held request from a one-cycle pulse. The cancel bit is written with debug enable low and then high. The sticky flags are cleared on their own, cleared in the same cycle as a set pulse, and cleared with the other clear bit, which shows set priority and that the clear bits are independent of each other.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

    localparam int DW          = 32;
    localparam int AW          = 2;
    localparam int N_EXC       = 3;
    localparam int N_STICKY    = N_EXC + 1;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_STAT = 2'd1;

    localparam int CB_HALT     = 0;
    localparam int CB_RESTART  = 1;
    localparam int CB_EXC_CLR  = 2;
    localparam int CB_PADV_CLR = 3;
    localparam int CB_CANCEL   = 4;

    localparam int SB_HALTED    = 0;
    localparam int SB_RESTARTED = 1;
    localparam int SB_EXC_LO    = 6;
    localparam int SB_PADV      = 25;

    typedef struct packed {
        logic cancel;
        logic padv_clr;
        logic exc_clr;
        logic restart;
        logic halt;
    } ctrl_cmd_t;

    typedef struct packed {
        logic             padv;
        logic [N_EXC-1:0] exc;
        logic             restarted;
        logic             halted;
    } stat_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic wr, input logic [DW-1:0] d);
        ctrl_cmd_t c;
        c.halt     = wr & d[CB_HALT];
        c.restart  = wr & d[CB_RESTART];
        c.exc_clr  = wr & d[CB_EXC_CLR];
        c.padv_clr = wr & d[CB_PADV_CLR];
        c.cancel   = wr & d[CB_CANCEL];
        return c;
    endfunction

    function automatic logic [DW-1:0] pack_status(input stat_t s);
        logic [DW-1:0] w;
        w = '0;
        w[SB_HALTED]                     = s.halted;
        w[SB_RESTARTED]                  = s.restarted;
        w[SB_EXC_LO +: N_EXC]            = s.exc;
        w[SB_PADV]                       = s.padv;
        return w;
    endfunction

endpackage

// File: rtl/dbg_runctl_sticky.sv
module dbg_runctl_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst)            q <= 1'b0;
            else if (set_i[i])  q <= 1'b1;
            else if (clr_i[i])  q <= 1'b0;
        end
        assign flag_o[i] = q;

        // set has priority over clear (R5, R6)
        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_o[i]);
        assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    end

endmodule

// File: rtl/dbg_runctl_req.sv
module dbg_runctl_req
    import dbg_runctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctrl_cmd_t cmd,
    input  logic      dbg_enable,
    input  logic      in_debug,
    output logic      halt_req,
    output logic      restart_req,
    output logic      cancel_req,
    output logic      restarted
);

    logic halt_q, restart_q, cancel_q, restarted_q, in_dbg_d;
    logic take_halt, take_restart, take_cancel, left_debug;

    assign take_halt    = cmd.halt & ~in_debug;
    assign take_restart = cmd.restart & in_debug;
    assign take_cancel  = cmd.cancel & dbg_enable & ~in_debug;
    assign left_debug   = in_dbg_d & ~in_debug;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q      <= 1'b0;
            restart_q   <= 1'b0;
            cancel_q    <= 1'b0;
            restarted_q <= 1'b0;
            in_dbg_d    <= in_debug;
        end else begin
            in_dbg_d  <= in_debug;
            halt_q    <= in_debug ? 1'b0 : (halt_q | take_halt);
            restart_q <= in_debug ? (restart_q | take_restart) : 1'b0;
            cancel_q  <= in_debug ? 1'b0 : (cancel_q | take_cancel);
            if (take_restart)    restarted_q <= 1'b0;
            else if (left_debug) restarted_q <= 1'b1;
        end
    end

    assign halt_req    = halt_q;
    assign restart_req = restart_q;
    assign cancel_req  = cancel_q;
    assign restarted   = restarted_q;

    assert_halt_drop_R1: assert property (@(posedge clk) disable iff (rst)
        in_debug |=> !halt_req);
    assert_halt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !in_debug) |=> halt_req);
    assert_restart_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !in_debug |=> !restart_req);
    assert_restart_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (restart_req && in_debug) |=> restart_req);
    assert_cancel_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (!cancel_req && !dbg_enable) |=> !cancel_req);
    assert_restarted_set_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(in_debug) |=> restarted);
    assert_one_req_R3: assert property (@(posedge clk) disable iff (rst)
        !(halt_req && restart_req));

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
    import dbg_runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              dbg_enable,
    input  logic              core_in_debug,
    input  logic [N_EXC-1:0]  core_exc_evt,
    input  logic              core_padv_evt,
    output logic              core_halt_req,
    output logic              core_restart_req,
    output logic              core_cancel_req
);

    ctrl_cmd_t             cmd;
    stat_t                 stat;
    logic                  restarted;
    logic [N_STICKY-1:0]   sticky_set, sticky_clr, sticky_q;

    assign cmd = decode_ctrl(reg_wr && (reg_addr == ADDR_CTRL), reg_wdata);

    dbg_runctl_req u_req (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .dbg_enable  (dbg_enable),
        .in_debug    (core_in_debug),
        .halt_req    (core_halt_req),
        .restart_req (core_restart_req),
        .cancel_req  (core_cancel_req),
        .restarted   (restarted)
    );

    assign sticky_set = {core_padv_evt, core_exc_evt};
    assign sticky_clr = {cmd.padv_clr, {N_EXC{cmd.exc_clr}}};

    dbg_runctl_sticky #(.N(N_STICKY)) u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_i  (sticky_set),
        .clr_i  (sticky_clr),
        .flag_o (sticky_q)
    );

    always_comb begin
        stat.halted    = core_in_debug;
        stat.restarted = restarted;
        stat.exc       = sticky_q[N_EXC-1:0];
        stat.padv      = sticky_q[N_EXC];
    end

    always_comb begin
        if (reg_addr == ADDR_STAT) reg_rdata = pack_status(stat);
        else                       reg_rdata = '0;
    end

    assert_halted_live_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STAT) |-> (reg_rdata[SB_HALTED] == core_in_debug));

endmodule

// File: tb/dbg_runctl_tb.sv
module dbg_runctl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        dbg_enable;
    logic        core_in_debug;
    logic [2:0]  core_exc_evt;
    logic        core_padv_evt;
    logic        core_halt_req, core_restart_req, core_cancel_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_runctl u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_stat(output logic [31:0] v);
        reg_addr = 2'd1; #1; v = reg_rdata;
    endtask

    task automatic set_dbg(input logic v);
        core_in_debug = v; tick();
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R9 halt", core_halt_req, 0);
        chk("R9 restart", core_restart_req, 0);
        chk("R9 cancel", core_cancel_req, 0);
        rd_stat(v); chk("R9 status", v, 0);
    endtask

    task automatic t_halt;
        logic [31:0] v;
        wr(2'd0, 32'h1);
        chk("R1 raise", core_halt_req, 1);
        tick(3);
        chk("R1 hold", core_halt_req, 1);
        reg_addr = 2'd0; #1; chk("R8 ctrl reads zero", reg_rdata, 0);
        core_in_debug = 1'b1;
        rd_stat(v); chk("R7 halted live", v[0], 1);
        tick();
        chk("R1 drop on entry", core_halt_req, 0);
        wr(2'd0, 32'h1);
        chk("R1 ignored in debug", core_halt_req, 0);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        wr(2'd0, 32'h2);
        chk("R2 raise", core_restart_req, 1);
        rd_stat(v); chk("R7 restarted cleared", v[1], 0);
        tick(2);
        chk("R2 hold", core_restart_req, 1);
        set_dbg(1'b0);
        chk("R2 drop on exit", core_restart_req, 0);
        rd_stat(v); chk("R7 restarted set", v[1:0], 2'b10);
        wr(2'd0, 32'h2);
        chk("R2 ignored running", core_restart_req, 0);
    endtask

    task automatic t_both;
        wr(2'd0, 32'h3);
        chk("R3 running halt", core_halt_req, 1);
        chk("R3 running restart", core_restart_req, 0);
        set_dbg(1'b1);
        wr(2'd0, 32'h3);
        chk("R3 debug restart", core_restart_req, 1);
        chk("R3 debug halt", core_halt_req, 0);
        set_dbg(1'b0);
    endtask

    task automatic t_cancel;
        dbg_enable = 1'b0;
        wr(2'd0, 32'h10);
        chk("R4 gated by enable", core_cancel_req, 0);
        dbg_enable = 1'b1;
        wr(2'd0, 32'h10);
        chk("R4 raise", core_cancel_req, 1);
        tick(2);
        chk("R4 hold", core_cancel_req, 1);
        set_dbg(1'b1);
        chk("R4 drop on entry", core_cancel_req, 0);
        set_dbg(1'b0);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        core_exc_evt = 3'b010; tick(); core_exc_evt = '0;
        rd_stat(v); chk("R5 exc set", v[8:6], 3'b010);
        core_padv_evt = 1'b1; tick(); core_padv_evt = 1'b0;
        rd_stat(v); chk("R6 padv set", v[25], 1);
        wr(2'd0, 32'h4);
        rd_stat(v); chk("R5 exc clear", v[8:6], 0);
        chk("R6 padv untouched by exc clear", v[25], 1);
        core_exc_evt = 3'b101; tick(); core_exc_evt = '0;
        wr(2'd0, 32'h8);
        rd_stat(v); chk("R6 padv clear", v[25], 0);
        chk("R6 exc untouched by padv clear", v[8:6], 3'b101);
        core_exc_evt = 3'b001; core_padv_evt = 1'b1;
        wr(2'd0, 32'hC);
        core_exc_evt = '0; core_padv_evt = 1'b0;
        rd_stat(v); chk("R5 set wins", v[8:6], 3'b001);
        chk("R6 set wins", v[25], 1);
        chk("R8 unused zero", v & ~32'h0200_01C3, 0);
        reg_addr = 2'd2; #1; chk("R8 other addr zero", reg_rdata, 0);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        dbg_enable = 1'b1; core_in_debug = 0; core_exc_evt = 0; core_padv_evt = 0;
        tick(3);
        rst = 1'b0;
        t_reset();
        t_halt();
        t_restart();
        t_both();
        t_cancel();
        t_sticky();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule